// File: doc/BRIEF.md
# Eight-Channel External Interrupt Controller

This block watches eight external interrupt pins and turns activity on them into a single interrupt request toward a CPU. Each pin is brought into the clock domain by a two-flop synchronizer. A per-channel two-bit sense field selects what counts as an event on that pin: a low level, any change, a falling edge or a rising edge. Edge-type events set a pending flag for the channel. Low-level channels never hold a flag: their request follows the synchronized pin directly.

Software reaches the block through a small register bus. It provides an enable mask, the pending flags (write one to clear), and two sense-control words. A channel requests service when its enable bit is one, its flag is set (or, in level mode, its pin is low), and the global interrupt enable is high. The lowest-numbered requesting channel wins, and its index is presented with the request. When the CPU services a channel, it pulses an acknowledge carrying that channel number, which clears the channel's flag.

The acknowledge is a single-beat strobe that is always accepted. It has no ready signal and is never back-pressured. The request output is a level, not a stream: it stays high as long as any enabled channel is active.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the mask register, the flag register and both sense words read zero. With every channel then in low-level mode and the mask at zero, `irq_req` is low.
- R2: `irq_req` is high only when `gie` is high and at least one channel with its mask bit set is active. A set flag whose mask bit is zero raises no request.
- R3: The sense code for channel n sits at bits [2(n mod 4)+1 : 2(n mod 4)] of sense word floor(n/4). The codes are 00 low level, 01 any change, 10 falling edge, 11 rising edge. An event of the selected kind sets the channel's flag whatever its mask bit holds.
- R4: The register map is: address 0 is the mask (bit n = channel n), address 1 is the flags (bit n = channel n), address 2 is sense word 0 and address 3 is sense word 1. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R5: When `ack_valid` is high, the flag of channel `ack_chan` is cleared on that clock edge.
- R6: A channel in low-level mode always reads a zero flag, including right after it is switched into that mode. It is active exactly while its synchronized pin is low.
- R7: When several channels are active, `irq_chan` reports the lowest-numbered one.
- R8: If an event and a clear (by write or by acknowledge) reach the same channel on the same edge, the flag ends up set.
- R9: Changing a channel's sense code never sets its flag by itself.
- R10: A pin change driven before clock edge k is synchronized over edges k and k+1, and sets the flag on edge k+2. It is not visible in the flag register before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 8 | External interrupt pins, asynchronous |
| gie | input | 1 | Global interrupt enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| ack_valid | input | 1 | CPU service acknowledge strobe |
| ack_chan | input | 3 | Channel being acknowledged |
| irq_req | output | 1 | Interrupt request |
| irq_chan | output | 3 | Index of the requesting channel, valid while `irq_req` is high |

## Verification
The assertions rely on two assumptions about the inputs. First, `ack_chan` is only meaningful while `ack_valid` is high. Second, bus writes and acknowledges are single-cycle strobes that are stable around the sampling edge. The bench drives every input on the falling clock edge, so the synchronizer and the register bus never see a change at the active edge. After every pin change it waits at least three edges before judging the flag, except in the latency and coincidence tests, which count edges exactly. Under those conditions the properties hold: a flag only rises after an observed event, level-mode channels keep zero flags, and a request implies `gie`, an enabled channel and no active lower-numbered channel.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int A_MASK   = 0;
  localparam int A_FLAG   = 1;
  localparam int A_SENSE0 = 2;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_channel.sv
module eirq_channel
  import eirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  sense_e sense,
  input  logic   clr,
  input  logic   en,
  output logic   flag_raw,
  output logic   flag_vis,
  output logic   lvl,
  output logic   evt,
  output logic   active
);
  logic prev_q;
  logic flag_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;
  assign lvl  = (sense == SENSE_LOW);

  always_comb begin
    unique case (sense)
      SENSE_ANY:  evt = rise | fall;
      SENSE_FALL: evt = fall;
      SENSE_RISE: evt = rise;
      default:    evt = 1'b0;
    endcase
  end

  // an event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (lvl) flag_q <= 1'b0;
    else if (evt) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag_raw = flag_q;
  assign flag_vis = flag_q & ~lvl;
  assign active   = en & (lvl ? ~pin_s : flag_q);
endmodule

// File: rtl/eirq_prio.sv
module eirq_prio #(
  parameter int N  = 8,
  parameter int CW = 3
) (
  input  logic [N-1:0]  act,
  output logic          found,
  output logic [CW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) idx = CW'(i);
    end
  end

  assign found = |act;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_in,
  input  logic           gie,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           ack_valid,
  input  logic [CW-1:0]  ack_chan,
  output logic           irq_req,
  output logic [CW-1:0]  irq_chan
);
  localparam int SWORDS = (2 * NCH + DW - 1) / DW;

  logic [NCH-1:0]       mask_q;
  logic [SWORDS*DW-1:0] sense_q;
  logic [NCH-1:0]       pin_s;
  logic [NCH-1:0]       flag_q, flag_vis, lvl_v, evt_v, act_v, clr_v;
  logic                 any_act;
  logic                 flag_wr;

  assign flag_wr = bus_we && (bus_addr == AW'(A_FLAG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      sense_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(A_MASK)) mask_q <= bus_wdata[NCH-1:0];
      for (int k = 0; k < SWORDS; k++) begin
        if (bus_addr == AW'(A_SENSE0 + k)) sense_q[k*DW +: DW] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_MASK)) bus_rdata[NCH-1:0] = mask_q;
    if (bus_addr == AW'(A_FLAG)) bus_rdata[NCH-1:0] = flag_vis;
    for (int k = 0; k < SWORDS; k++) begin
      if (bus_addr == AW'(A_SENSE0 + k)) bus_rdata = sense_q[k*DW +: DW];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign clr_v[i] = (flag_wr && bus_wdata[i]) ||
                      (ack_valid && (ack_chan == CW'(i)));

    eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in[i]),
      .q     (pin_s[i])
    );

    eirq_channel u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_s    (pin_s[i]),
      .sense    (sense_e'(sense_q[2*i +: 2])),
      .clr      (clr_v[i]),
      .en       (mask_q[i]),
      .flag_raw (flag_q[i]),
      .flag_vis (flag_vis[i]),
      .lvl      (lvl_v[i]),
      .evt      (evt_v[i]),
      .active   (act_v[i])
    );
  end

  eirq_prio #(.N(NCH), .CW(CW)) u_prio (
    .act   (act_v),
    .found (any_act),
    .idx   (irq_chan)
  );

  assign irq_req = gie & any_act;
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           gie,
  input logic           irq_req,
  input logic [CW-1:0]  irq_chan,
  input logic [NCH-1:0] mask,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] lvl,
  input logic [NCH-1:0] evt
);
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie); // R2
  AST_REQ_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> mask[irq_chan]); // R2
  AST_NO_LOWER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((mask & flags & ~lvl & ((NCH'(1) << irq_chan) - NCH'(1))) == '0)); // R7
  AST_LEVEL_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & $past(lvl)) == '0); // R6
  AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags) & ~$past(evt)) == '0); // R3
endmodule

bind ext_irq_ctrl eirq_checker #(.NCH(NCH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gie      (gie),
  .irq_req  (irq_req),
  .irq_chan (irq_chan),
  .mask     (mask_q),
  .flags    (flag_q),
  .lvl      (lvl_v),
  .evt      (evt_v)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       gie = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ack_v = 1'b0;
  logic [2:0] ack_c = '0;
  logic       irq;
  logic [2:0] ichan;
  logic [15:0] sense_sh = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .gie(gie),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .ack_valid(ack_v), .ack_chan(ack_c), .irq_req(irq), .irq_chan(ichan)
  );

  // vector: [7:5] channel, [4:3] sense code, [2] start pin, [1] end pin, [0] expected flag
  localparam logic [7:0] VEC [8] = '{
    {3'd0, 2'b11, 1'b0, 1'b1, 1'b1},
    {3'd1, 2'b11, 1'b1, 1'b0, 1'b0},
    {3'd2, 2'b10, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'b10, 1'b0, 1'b1, 1'b0},
    {3'd4, 2'b01, 1'b0, 1'b1, 1'b1},
    {3'd5, 2'b01, 1'b1, 1'b0, 1'b1},
    {3'd6, 2'b00, 1'b1, 1'b0, 1'b0},
    {3'd7, 2'b01, 1'b1, 1'b1, 1'b0}
  };

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_sense(input int ch, input logic [1:0] code);
    sense_sh[2*ch +: 2] = code;
    wr(2'd2, sense_sh[7:0]);
    wr(2'd3, sense_sh[15:8]);
  endtask

  task automatic ack(input logic [2:0] c);
    @(negedge clk);
    ack_v = 1'b1; ack_c = c;
    @(negedge clk);
    ack_v = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    // R1 reset state
    rd(2'd0, r); chk("R1 mask", r, 8'h00);
    rd(2'd1, r); chk("R1 flag", r, 8'h00);
    rd(2'd2, r); chk("R1 sense0", r, 8'h00);
    rd(2'd3, r); chk("R1 sense1", r, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // all channels rising edge, enabled, gie on
    sense_sh = 16'hFFFF;
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd3, r); chk("R4 sense readback", r, 8'hFF);
    wr(2'd0, 8'hFF);
    gie = 1'b1;
    wr(2'd1, 8'hFF);

    // table of sense cases (R3, R6)
    for (int v = 0; v < 8; v++) begin
      int ch;
      logic [1:0] md;
      logic ef, ereq;
      ch = int'(VEC[v][7:5]);
      md = VEC[v][4:3];
      ef = VEC[v][0];
      set_sense(ch, md);
      pins[ch] = VEC[v][2];
      waitn(4);
      wr(2'd1, 8'hFF);
      pins[ch] = VEC[v][1];
      waitn(4);
      rd(2'd1, r);
      chk("R3 table flag", r, 8'(ef) << ch);
      ereq = (md == 2'b00) ? ~VEC[v][1] : ef;
      chk("R6 table irq", {7'd0, irq}, {7'd0, ereq});
      if (ereq) chk("R7 table chan", {5'd0, ichan}, 8'(ch));
      set_sense(ch, 2'b11);
      wr(2'd1, 8'hFF);
    end

    pins = '0;
    waitn(4);
    wr(2'd1, 8'hFF);

    // R2 / R3: flag sets with mask clear, no request
    wr(2'd0, 8'h00);
    pins[1] = 1'b1;
    waitn(4);
    rd(2'd1, r); chk("R3 flag without mask", r, 8'h02);
    chk("R2 masked no irq", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'hFF);
    chk("R2 irq when enabled", {7'd0, irq}, 8'h01);
    gie = 1'b0;
    waitn(1);
    chk("R2 gie low blocks", {7'd0, irq}, 8'h00);
    gie = 1'b1;

    // R7 priority, R5 acknowledge
    pins[5] = 1'b1;
    waitn(4);
    chk("R7 lowest chan", {5'd0, ichan}, 8'd1);
    ack(3'd1);
    rd(2'd1, r); chk("R5 ack clears", r, 8'h20);
    chk("R7 next chan", {5'd0, ichan}, 8'd5);

    // R4 write zero ignored, write one clears
    wr(2'd1, 8'h00);
    rd(2'd1, r); chk("R4 write zero keeps", r, 8'h20);
    wr(2'd1, 8'h20);
    rd(2'd1, r); chk("R4 write one clears", r, 8'h00);
    chk("R4 irq gone", {7'd0, irq}, 8'h00);

    // R8 edge and clear on the same edge
    @(negedge clk); pins[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd1; wdata = 8'h04;
    @(negedge clk); we = 1'b0;
    rd(2'd1, r); chk("R8 edge beats write clear", r, 8'h04);
    wr(2'd1, 8'hFF);
    @(negedge clk); pins[2] = 1'b0;
    set_sense(2, 2'b10);
    wr(2'd1, 8'hFF);
    @(negedge clk); pins[2] = 1'b1;
    @(negedge clk); pins[2] = 1'b0;
    @(negedge clk);
    @(negedge clk); ack_v = 1'b1; ack_c = 3'd2;
    @(negedge clk); ack_v = 1'b0;
    rd(2'd1, r); chk("R8 edge beats ack", r, 8'h04);
    set_sense(2, 2'b11);
    wr(2'd1, 8'hFF);

    // R9 mode changes set no flag
    pins[3] = 1'b1;
    waitn(4);
    wr(2'd1, 8'hFF);
    set_sense(3, 2'b10);
    set_sense(3, 2'b01);
    set_sense(3, 2'b11);
    waitn(3);
    rd(2'd1, r); chk("R9 mode change no flag", r, 8'h00);

    // R6 switching to level hides flag; request follows low pin
    pins[4] = 1'b1;
    waitn(4);
    rd(2'd1, r); chk("R3 ch4 rise flag", r, 8'h10);
    set_sense(4, 2'b00);
    rd(2'd1, r); chk("R6 level flag zero", r, 8'h00);
    chk("R6 high pin no irq", {7'd0, irq}, 8'h00);
    pins[4] = 1'b0;
    waitn(3);
    chk("R6 low pin irq", {7'd0, irq}, 8'h01);
    chk("R6 low pin chan", {5'd0, ichan}, 8'd4);
    rd(2'd1, r); chk("R6 flag stays zero", r, 8'h00);
    set_sense(4, 2'b11);
    waitn(3);
    rd(2'd1, r); chk("R9 back to edge no flag", r, 8'h00);

    // R10 latency
    @(negedge clk); pins[7] = 1'b1;
    waitn(2);
    rd(2'd1, r); chk("R10 not before third edge", r, 8'h00);
    waitn(1);
    rd(2'd1, r); chk("R10 set on third edge", r, 8'h80);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule